// File: doc/BRIEF.md
# Programmable Binary Timer Divider

This block is a 24-stage binary counter whose count is driven by a slow external clock input. A fast system clock samples that input, and the counter advances once on each falling edge of the input. A 4-bit stage-select code and a skip control choose one stage of the chain. That stage drives a decoded output, so the decoded output is the input divided by a power of two. Two more outputs carry the input itself, undivided, and the full stage vector is visible for test.

The set and reset controls work together to pick a mode. Reset alone clears the chain. Set and reset together split the chain into three 8-stage lanes that count side by side, so every stage can reach the all-ones state in 255 input edges. Returning both to low rejoins the lanes into one chain without losing the contents. A rising edge on set also forces the decoded output high and arms it. The first counted input edge after that drives the output low. A clock-hold input blocks all input edges while it is high.

Top module: `btd_top`

## Requirements
- R1: With set and reset low and skip low, the 24-bit stage vector increments by one, modulo 2^24, on each falling edge of the clock input that is counted, so all ones wraps to zero.
- R2: While reset is high and set is low, the stage vector is cleared to zero and stays there, whatever the clock input does.
- R3: While set and reset are both high, bits [7:0], [15:8] and [23:16] each increment by one modulo 256 on every counted falling edge. From zero, 255 edges give 24'hFFFFFF.
- R4: When set and reset fall to low together, the stage vector keeps its value. From all ones, the next counted edge rolls it to zero.
- R5: While hold is high, falling edges on the clock input change neither the stage vector nor the decoded output.
- R6: A rising edge on set drives the decoded output high one system-clock cycle later.
- R7: The first counted falling edge after a rising edge on set drives the decoded output low.
- R8: After that first edge, each counted edge sets the decoded output to bit 8+n of the updated stage vector, where n is the select code. With skip low this divides the input by 2^(n+9).
- R9: With skip high (and not in lane mode), bits [7:0] are frozen and bits [23:8] count as one 16-bit counter. The decoded output then divides the input by 2^(n+1).
- R10: Both pass-through outputs equal the clock input delayed by two system-clock cycles.
- R11: Under an active-low synchronous reset, the stage vector, the decoded output and both pass-through outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_i | input | 1 | Clock input to be divided, asynchronous to clk |
| preset_i | input | 1 | Set control: rising edge arms the decoded output, and together with clear_i selects lane mode |
| clear_i | input | 1 | Reset control: clears the chain when high alone |
| hold_i | input | 1 | Clock hold: blocks input edges while high |
| skip8_i | input | 1 | Skips the first eight stages in the count path |
| tap_sel_i | input | 4 | Stage select code n |
| dec_o | output | 1 | Decoded (divided) output |
| thru_a_o | output | 1 | Synchronised copy of the clock input |
| thru_b_o | output | 1 | Second synchronised copy of the clock input |
| stages_o | output | 24 | Full stage vector for test |

## Verification
The bench runs the full lane-mode test sequence: it clears the chain, fills all lanes to ones in 255 edges, rejoins them, and applies one edge to roll the chain to zero. A lane carry that leaks into the next lane, or a rejoin that clears the chain, shows up there as a wrong vector. With skip high, the divide ratio is measured for select codes 0, 1 and 2. With skip low, the first high phase of the tap is checked at edge 256. A wrong tap offset, or low stages that keep counting under skip, changes the count of output rises. Random runs mix hold, set pulses, skip and select changes. These catch an output that ignores the arm-low rule or moves while hold is high.

// File: rtl/btd_pkg.sv
// Package: shared constants and the mode type for the binary timer divider.
// Assumes a chain made of whole 8-stage lanes.
package btd_pkg;
    localparam int BTD_STAGES = 24;
    localparam int BTD_LANE_W = 8;
    localparam int BTD_SEL_W  = 4;

    // Count-path configuration decoded from the set/reset/skip controls.
    typedef enum logic [1:0] {
        MODE_SERIES = 2'd0,
        MODE_SKIP   = 2'd1,
        MODE_LANES  = 2'd2,
        MODE_CLEAR  = 2'd3
    } btd_mode_e;
endpackage

// File: rtl/btd_sync_fall.sv
// Module: brings an asynchronous level onto clk through a DEPTH-flop chain.
// Reports a one-cycle pulse on each high-to-low change of the synchronised value.
// Assumes the input stays stable for at least two clk cycles per level.
module btd_sync_fall #(
    parameter int DEPTH = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic level_o,
    output logic fall_o
);
    logic [DEPTH-1:0] chain_q;
    logic             last_q;

    // Purpose: shift the raw input through the synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[DEPTH-2:0], async_i};
    end

    // Purpose: remember the previous synchronised level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) last_q <= 1'b0;
        else        last_q <= chain_q[DEPTH-1];
    end

    assign level_o = chain_q[DEPTH-1];
    assign fall_o  = last_q & ~chain_q[DEPTH-1];

    // R10: the synchronised level follows the input sampled DEPTH cycles earlier.
    a_r10_sync_follow: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(chain_q[0]) |=> chain_q[1]);
endmodule

// File: rtl/btd_mode_ctl.sv
// Module: decodes the set, reset and skip controls into a count-path mode.
// Also detects rising edges on set.
// Assumes the controls are synchronous to clk.
module btd_mode_ctl
    import btd_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      preset_i,
    input  logic      clear_i,
    input  logic      skip8_i,
    output btd_mode_e mode_o,
    output logic      preset_rise_o
);
    logic preset_q;

    // Purpose: hold the previous value of set for rise detection.
    always_ff @(posedge clk) begin
        if (!rst_n) preset_q <= 1'b0;
        else        preset_q <= preset_i;
    end

    // Purpose: map the control levels to a mode, with lane mode taking priority.
    always_comb begin
        if (preset_i && clear_i)       mode_o = MODE_LANES;
        else if (clear_i)              mode_o = MODE_CLEAR;
        else if (skip8_i)              mode_o = MODE_SKIP;
        else                           mode_o = MODE_SERIES;
    end

    assign preset_rise_o = preset_i & ~preset_q;
endmodule

// File: rtl/btd_stage_chain.sv
// Module: the stage vector. It counts as one chain, as a chain that skips the
// low lane, or as independent lanes, and it clears in clear mode.
// Assumes STAGES is a multiple of LANE_W. advance_i is a one-cycle pulse.
module btd_stage_chain
    import btd_pkg::*;
#(
    parameter int STAGES = BTD_STAGES,
    parameter int LANE_W = BTD_LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  btd_mode_e         mode_i,
    input  logic              advance_i,
    output logic [STAGES-1:0] stages_o,
    output logic [STAGES-1:0] stages_nxt_o
);
    localparam int LANES  = STAGES / LANE_W;
    localparam int HIGH_W = STAGES - LANE_W;

    logic [STAGES-1:0] cnt_q;
    logic [STAGES-1:0] lane_inc;
    logic [STAGES-1:0] full_inc;
    logic [STAGES-1:0] skip_inc;

    // Purpose: one independent incrementer per lane for lane mode.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_inc[g*LANE_W +: LANE_W] =
            cnt_q[g*LANE_W +: LANE_W] + {{(LANE_W-1){1'b0}}, 1'b1};
    end

    assign full_inc = cnt_q + {{(STAGES-1){1'b0}}, 1'b1};
    assign skip_inc = {cnt_q[STAGES-1:LANE_W] + {{(HIGH_W-1){1'b0}}, 1'b1},
                       cnt_q[LANE_W-1:0]};

    // Purpose: choose the next stage vector from the mode and the advance pulse.
    always_comb begin
        stages_nxt_o = cnt_q;
        if (mode_i == MODE_CLEAR) begin
            stages_nxt_o = '0;
        end else if (advance_i) begin
            case (mode_i)
                MODE_LANES: stages_nxt_o = lane_inc;
                MODE_SKIP:  stages_nxt_o = skip_inc;
                default:    stages_nxt_o = full_inc;
            endcase
        end
    end

    // Purpose: register the stage vector.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= stages_nxt_o;
    end

    assign stages_o = cnt_q;

    // R2: clear mode leaves the chain at zero on the next cycle.
    a_r2_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == MODE_CLEAR) |=> (cnt_q == '0));
    // R1: one series step adds exactly one to the whole chain.
    a_r1_series_step: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == MODE_SERIES && advance_i) |=>
        (cnt_q == STAGES'($past(cnt_q) + 1)));
    // R3: the lowest lane wraps on its own in lane mode.
    a_r3_lane_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == MODE_LANES && advance_i) |=>
        (cnt_q[LANE_W-1:0] == LANE_W'($past(cnt_q[LANE_W-1:0]) + 1)));
    // R9: the skipped low lane never moves in skip mode.
    a_r9_low_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == MODE_SKIP) |=> $stable(cnt_q[LANE_W-1:0]));
endmodule

// File: rtl/btd_tap_flag.sv
// Module: the decoded output. A rise on set forces it high and arms it. The
// first counted edge after that drives it low, and each later counted edge
// loads the selected stage of the updated chain.
// Assumes the tap index LANE_W + sel lies inside the chain.
module btd_tap_flag #(
    parameter int STAGES = 24,
    parameter int LANE_W = 8,
    parameter int SEL_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              preset_rise_i,
    input  logic              advance_i,
    input  logic [SEL_W-1:0]  sel_i,
    input  logic [STAGES-1:0] stages_nxt_i,
    output logic              dec_o
);
    localparam int IDX_W = $clog2(STAGES);

    logic [IDX_W-1:0] tap_idx;
    logic             armed_q;
    logic             dec_q;

    assign tap_idx = IDX_W'(LANE_W) + IDX_W'(sel_i);

    // Purpose: update the output flag and the arm bit. The set rise has priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_q   <= 1'b0;
            armed_q <= 1'b0;
        end else if (preset_rise_i) begin
            dec_q   <= 1'b1;
            armed_q <= 1'b1;
        end else if (advance_i) begin
            dec_q   <= armed_q ? 1'b0 : stages_nxt_i[tap_idx];
            armed_q <= 1'b0;
        end
    end

    assign dec_o = dec_q;

    // R6: a rise on set gives a high output next cycle.
    a_r6_set_high: assert property (@(posedge clk) disable iff (!rst_n)
        preset_rise_i |=> dec_q);
    // R7: the first counted edge while armed drives the output low.
    a_r7_first_low: assert property (@(posedge clk) disable iff (!rst_n)
        (advance_i && armed_q && !preset_rise_i) |=> !dec_q);
endmodule

// File: rtl/btd_top.sv
// Module: top of the programmable binary timer divider. It wires the input
// synchroniser, mode decode, stage chain and decoded-output flag.
// Assumes the set/reset/hold/skip/select inputs are synchronous to clk.
module btd_top
    import btd_pkg::*;
#(
    parameter int STAGES     = BTD_STAGES,
    parameter int LANE_W     = BTD_LANE_W,
    parameter int SEL_W      = BTD_SEL_W,
    parameter int SYNC_DEPTH = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              preset_i,
    input  logic              clear_i,
    input  logic              hold_i,
    input  logic              skip8_i,
    input  logic [SEL_W-1:0]  tap_sel_i,
    output logic              dec_o,
    output logic              thru_a_o,
    output logic              thru_b_o,
    output logic [STAGES-1:0] stages_o
);
    logic              tick_lvl;
    logic              tick_fall;
    logic              preset_rise;
    logic              advance;
    btd_mode_e         mode;
    logic [STAGES-1:0] stages_nxt;

    btd_sync_fall #(.DEPTH(SYNC_DEPTH)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (tick_i),
        .level_o (tick_lvl),
        .fall_o  (tick_fall)
    );

    btd_mode_ctl u_mode (
        .clk           (clk),
        .rst_n         (rst_n),
        .preset_i      (preset_i),
        .clear_i       (clear_i),
        .skip8_i       (skip8_i),
        .mode_o        (mode),
        .preset_rise_o (preset_rise)
    );

    // Purpose: count an input edge only when not held and not clearing.
    assign advance = tick_fall & ~hold_i & (mode != MODE_CLEAR);

    btd_stage_chain #(.STAGES(STAGES), .LANE_W(LANE_W)) u_chain (
        .clk          (clk),
        .rst_n        (rst_n),
        .mode_i       (mode),
        .advance_i    (advance),
        .stages_o     (stages_o),
        .stages_nxt_o (stages_nxt)
    );

    btd_tap_flag #(.STAGES(STAGES), .LANE_W(LANE_W), .SEL_W(SEL_W)) u_flag (
        .clk           (clk),
        .rst_n         (rst_n),
        .preset_rise_i (preset_rise),
        .advance_i     (advance),
        .sel_i         (tap_sel_i),
        .stages_nxt_i  (stages_nxt),
        .dec_o         (dec_o)
    );

    assign thru_a_o = tick_lvl;
    assign thru_b_o = tick_lvl;

    // R5: while held outside clear mode, neither the chain nor the output moves.
    a_r5_hold_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_i && mode != MODE_CLEAR && !preset_rise) |=>
        ($stable(stages_o) && $stable(dec_o)));
endmodule

// File: tb/sim_btd_top.sv
// Bench: directed lane-mode sequence and divide checks, then seeded random runs.
// Everything is checked against a bench-side model.
module sim_btd_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        preset = 1'b0;
    logic        clr = 1'b0;
    logic        hold = 1'b0;
    logic        skip = 1'b0;
    logic [3:0]  sel = 4'd0;
    logic        dec, thru_a, thru_b;
    logic [23:0] stages;

    int unsigned vectors = 0;
    int unsigned fails = 0;
    int unsigned cycles = 0;

    logic [23:0] m_cnt = '0;
    logic        m_dec = 1'b0;
    logic        m_armed = 1'b0;

    always #4 clk = ~clk;

    btd_top u0 (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .preset_i(preset),
        .clear_i(clr), .hold_i(hold), .skip8_i(skip), .tap_sel_i(sel),
        .dec_o(dec), .thru_a_o(thru_a), .thru_b_o(thru_b), .stages_o(stages)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Model of one counted falling edge.
    function automatic void model_edge();
        if (clr && !preset) return;
        if (hold) return;
        if (preset && clr) begin
            for (int g = 0; g < 3; g++) m_cnt[g*8 +: 8] = m_cnt[g*8 +: 8] + 8'd1;
        end else if (skip) begin
            m_cnt[23:8] = m_cnt[23:8] + 16'd1;
        end else begin
            m_cnt = m_cnt + 24'd1;
        end
        m_dec   = m_armed ? 1'b0 : m_cnt[8 + sel];
        m_armed = 1'b0;
    endfunction

    // One full input period. Checks the pass-through delay (R10) on the way.
    task automatic tick_edge(input bit chk_thru);
        tick = 1'b1;
        @(negedge clk);
        if (chk_thru) check(thru_a == 1'b0, "R10 thru before delay", 32'(thru_a), 32'd0);
        @(negedge clk);
        if (chk_thru) check(thru_a && thru_b, "R10 thru after delay",
                            32'({thru_a, thru_b}), 32'd3);
        @(negedge clk);
        tick = 1'b0;
        repeat (4) @(negedge clk);
        model_edge();
    endtask

    task automatic set_ctl(input logic s, input logic r);
        if (s && !preset) begin
            m_dec = 1'b1;
            m_armed = 1'b1;
        end
        preset = s;
        clr = r;
        if (r && !s) m_cnt = '0;
        @(negedge clk);
    endtask

    task automatic check_state(input string req);
        check(stages == m_cnt, req, 32'(stages), 32'(m_cnt));
        check(dec == m_dec, req, 32'(dec), 32'(m_dec));
    endtask

    // Watchdog: a hung run counts as a failed check and still prints the summary.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000) begin
            fails++;
            vectors++;
            $display("FAIL watchdog actual=%0d expected=<190000", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        int unsigned seed = 32'd1234;
        int unsigned rises;
        logic prev_dec;
        void'($urandom(seed));

        // Reset state.
        repeat (3) @(negedge clk);
        check(stages == 24'd0 && dec == 1'b0 && thru_a == 1'b0 && thru_b == 1'b0,
              "R11 reset state", 32'({stages, dec}), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: clear holds zero while input edges arrive.
        set_ctl(1'b0, 1'b1);
        for (int i = 0; i < 3; i++) tick_edge(i == 0);
        check(stages == 24'd0, "R2 clear holds zero", 32'(stages), 32'd0);

        // R3: lane mode entered with a set rise (R6).
        set_ctl(1'b1, 1'b1);
        check(dec == 1'b1, "R6 set rise high", 32'(dec), 32'd1);
        tick_edge(1'b0);
        check(stages == 24'h010101, "R3 lanes after one edge", 32'(stages), 32'h010101);
        check(dec == 1'b0, "R7 first edge low", 32'(dec), 32'd0);
        for (int i = 1; i < 255; i++) tick_edge(1'b0);
        check(stages == 24'hFFFFFF, "R3 lanes all ones", 32'(stages), 32'hFFFFFF);

        // R4: rejoin keeps contents, then one edge rolls to zero.
        set_ctl(1'b0, 1'b0);
        check(stages == 24'hFFFFFF, "R4 rejoin keeps", 32'(stages), 32'hFFFFFF);
        tick_edge(1'b0);
        check(stages == 24'd0, "R4 R1 rollover", 32'(stages), 32'd0);
        check_state("R8 after rollover");

        // R5: hold blocks edges.
        tick_edge(1'b0);
        hold = 1'b1;
        for (int i = 0; i < 5; i++) tick_edge(1'b0);
        check(stages == 24'd1, "R5 hold count", 32'(stages), 32'd1);
        check_state("R5 hold state");
        hold = 1'b0;

        // R9: skip mode divide ratio for select codes 0, 1, 2.
        for (int n = 0; n < 3; n++) begin
            set_ctl(1'b0, 1'b1);
            set_ctl(1'b1, 1'b0);
            set_ctl(1'b0, 1'b0);
            skip = 1'b1;
            sel = 4'(n);
            tick_edge(1'b0);
            rises = 0;
            prev_dec = dec;
            for (int i = 0; i < 16; i++) begin
                tick_edge(1'b0);
                if (dec && !prev_dec) rises++;
                prev_dec = dec;
                check(dec == m_dec, "R9 skip tap per edge", 32'(dec), 32'(m_dec));
            end
            check(rises == 16 / (2 << n), "R9 skip divide ratio", rises, 16 / (2 << n));
            check(stages[7:0] == 8'd0, "R9 low lane frozen", 32'(stages[7:0]), 32'd0);
        end
        skip = 1'b0;

        // R8: skip low, code 0, from zero: the output goes high on edge 256.
        set_ctl(1'b0, 1'b1);
        set_ctl(1'b1, 1'b0);
        set_ctl(1'b0, 1'b0);
        sel = 4'd0;
        for (int i = 1; i <= 300; i++) begin
            tick_edge(1'b0);
            if (i == 255) check(dec == 1'b0, "R8 tap low before 256", 32'(dec), 32'd0);
            if (i == 256) check(dec == 1'b1, "R8 tap high at 256", 32'(dec), 32'd1);
        end
        check_state("R8 R1 series run");

        // Random mix of hold, skip, select and set pulses.
        for (int it = 0; it < 30; it++) begin
            skip = 1'($urandom_range(0, 1));
            sel  = 4'($urandom_range(0, 3));
            hold = ($urandom_range(0, 3) == 0);
            if ($urandom_range(0, 3) == 0) begin
                set_ctl(1'b1, 1'b0);
                set_ctl(1'b0, 1'b0);
                check(dec == m_dec, "R6 random set", 32'(dec), 32'(m_dec));
            end
            if ($urandom_range(0, 7) == 0) set_ctl(1'b0, 1'b1);
            set_ctl(1'b0, 1'b0);
            for (int k = 0; k < int'($urandom_range(1, 40)); k++) tick_edge(k == 0);
            check_state("R1 R5 R7 R8 R9 random batch");
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule